// File: doc/BRIEF.md
# Timer-Paced Serial Shifter

This block holds one data word in a buffer and moves it serially through a shift register. An external timer supplies all of its timing: a load strobe, a store strobe, and two shift strobes, one for the rising edge and one for the falling edge. The block has no counter of its own.

In transmit mode a load strobe copies the buffer into the shift register. The word then leaves least-significant bit first on a selected output. A start bit can go in front of the word and a stop bit after it. When the stop bit is enabled, the output goes to the stop level as soon as transmit mode is entered. In receive mode, serial bits come in from one of several synchronised input pins, or from the output of a neighbouring shifter. A store strobe copies the received word into the buffer. The word length is taken from the timer's compare value.

Software can poll a single buffer flag, or use it as an interrupt or DMA request. A sticky error bit reports a word stored while the buffer was still unread.

Top module: `shift_engine`

## Requirements
- R1: With `mode_i`=2 (transmit), a `tmr_load_i` pulse copies the buffer into the shift register, and the first frame bit appears on `data_o` in the cycle after the load edge. A load takes priority over a shift in the same cycle.
- R2: In transmit mode, each selected shift strobe advances the frame by one bit. Data bits leave least-significant bit first. Once the frame is exhausted, the output holds the fill level, which equals `stop_en_i`.
- R3: With `start_en_i`=1, the frame starts with a start bit of 0, and data bit 0 follows it.
- R4: With `stop_en_i`=1, a stop bit of 1 follows the last data bit. With `stop_en_i`=0, the fill level after the data is 0.
- R5: In the first cycle of transmit mode, `data_o` is 1. From the next cycle until the first load, `data_o` equals `stop_en_i`.
- R6: With `shift_edge_i`=0, only `tmr_shift_pos_i` shifts. With `shift_edge_i`=1, only `tmr_shift_neg_i` shifts. The other strobe has no effect on the output.
- R7: `pin_o` equals `data_o` XOR `pin_inv_i`. The same inversion is applied to the selected input pin.
- R8: With `chain_sel_i`=0, the serial input is `pin_i[pin_sel_i]`, taken after a two-flop synchroniser. With `chain_sel_i`=1, it is `chain_i`, used directly with no inversion.
- R9: With `mode_i`=1 (receive), each selected shift strobe shifts one bit in. A `tmr_store_i` pulse writes the last N received bits to the buffer, with the first-received bit at bit 0. N = (`word_cmp_i`+1)/2 rounded down. When N is 0 or greater than WIDTH, N = WIDTH.
- R10: In transmit mode, `flag_o` is 1 while the buffer is empty: a write clears it and a load sets it. In receive mode, `flag_o` is 1 while the buffer is full: a store sets it and a `buf_re_i` pulse clears it. In any other mode, `flag_o` is 0.
- R11: A store in receive mode, while the buffer is full and not being read in the same cycle, sets `overrun_o`. The bit stays set until an `err_clr_i` pulse clears it.
- R12: With `mode_i`=0 or 3 (off), timer strobes are ignored, `data_o` is 1, and the buffer changes only through `buf_we_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0/3 off, 1 receive, 2 transmit |
| start_en_i | input | 1 | Enable start bit |
| stop_en_i | input | 1 | Enable stop bit / fill level |
| shift_edge_i | input | 1 | 0: rising shift strobe, 1: falling shift strobe |
| pin_inv_i | input | 1 | Invert pin output and pin input |
| chain_sel_i | input | 1 | Take serial input from neighbour shifter |
| pin_sel_i | input | $clog2(NPIN) | Input pin select |
| word_cmp_i | input | CW | Timer compare value setting word length |
| buf_wdata_i | input | WIDTH | Buffer write data |
| buf_we_i | input | 1 | Buffer write strobe |
| buf_re_i | input | 1 | Buffer read strobe |
| err_clr_i | input | 1 | Clear overrun |
| tmr_load_i | input | 1 | Timer load strobe |
| tmr_store_i | input | 1 | Timer store strobe |
| tmr_shift_pos_i | input | 1 | Timer rising-edge shift strobe |
| tmr_shift_neg_i | input | 1 | Timer falling-edge shift strobe |
| pin_i | input | NPIN | Serial input pins |
| chain_i | input | 1 | Neighbour shifter output |
| buf_rdata_o | output | WIDTH | Buffer contents |
| flag_o | output | 1 | Buffer status |
| overrun_o | output | 1 | Sticky overrun |
| pin_o | output | 1 | Serial pin output |
| data_o | output | 1 | Uninverted shifter output for chaining |

## Verification
Transmit is tested with all 256 byte values. Each value is sent under all four start/stop framings, with both strobe edges, and with the inversion toggled by the data. This set separates bit-order faults from framing faults, and framing faults from edge-select faults. Before the first shift of each frame, a pulse on the non-selected strobe shows whether the wrong edge is being used. Receive is tested with every byte value through a pin, with the other pins driven to the opposite level to expose a wrong pin select. A second pass uses the chain input. Further runs at several compare values check how short words are aligned, including the value that clamps to zero length and the one that clamps to oversize.

// File: rtl/shf_pkg.sv
`timescale 1ns/1ps
package shf_pkg;
  localparam logic [1:0] SM_OFF = 2'd0;
  localparam logic [1:0] SM_RX  = 2'd1;
  localparam logic [1:0] SM_TX  = 2'd2;
endpackage

// File: rtl/shf_sync.sv
`timescale 1ns/1ps
module shf_sync #(
  parameter int NPIN   = 4,
  parameter int STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] d_i,
  output logic [NPIN-1:0] q_o
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [STAGES-1:0] st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= '0;
      else         st_q <= {st_q[STAGES-2:0], d_i[p]};
    end
    assign q_o[p] = st_q[STAGES-1];
  end
endmodule

// File: rtl/shf_frame.sv
`timescale 1ns/1ps
module shf_frame #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  input  logic             tx_enter_i,
  input  logic             start_en_i,
  input  logic             stop_en_i,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             in_bit_i,
  input  logic [WIDTH-1:0] buf_i,
  output logic             out_bit_o,
  output logic [WIDTH-1:0] rx_word_o
);
  localparam int SW = WIDTH + 2;

  logic [SW-1:0] sr_q;
  logic [SW-1:0] frame;

  always_comb begin
    frame = {SW{stop_en_i}};
    if (start_en_i) frame[WIDTH:0]   = {buf_i, 1'b0};
    else            frame[WIDTH-1:0] = buf_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '1;
    end else if (tx_en_i) begin
      if (load_i)          sr_q <= frame;
      else if (tx_enter_i) sr_q <= {SW{stop_en_i}};
      else if (shift_i)    sr_q <= {stop_en_i, sr_q[SW-1:1]};
    end else if (rx_en_i && shift_i) begin
      sr_q <= {sr_q[SW-1:WIDTH], in_bit_i, sr_q[WIDTH-1:1]};
    end
  end

  // first transmit cycle shows idle level until the preload lands
  assign out_bit_o = (tx_en_i && !tx_enter_i) ? sr_q[0] : 1'b1;
  assign rx_word_o = sr_q[WIDTH-1:0];
endmodule

// File: rtl/shf_buf.sv
`timescale 1ns/1ps
module shf_buf #(
  parameter int WIDTH = 8,
  parameter int CW    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic             load_i,
  input  logic             store_i,
  input  logic             err_clr_i,
  input  logic [CW-1:0]    cmp_i,
  input  logic [WIDTH-1:0] rx_word_i,
  output logic [WIDTH-1:0] buf_o,
  output logic             flag_o,
  output logic             overrun_o
);
  localparam int LW = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] buf_q;
  logic             full_q, full_d;
  logic             ovr_q;
  logic [CW:0]      nbits;
  logic [LW-1:0]    wlen;
  logic [LW-1:0]    sh;
  logic [WIDTH-1:0] aligned;
  logic             do_store, do_load;

  assign do_store = rx_en_i && store_i;
  assign do_load  = tx_en_i && load_i;

  always_comb begin
    nbits = ({1'b0, cmp_i} + (CW+1)'(1)) >> 1;
    if (nbits == '0 || nbits > (CW+1)'(WIDTH)) wlen = LW'(WIDTH);
    else                                       wlen = nbits[LW-1:0];
    sh      = LW'(WIDTH) - wlen;
    aligned = rx_word_i >> sh;
  end

  always_comb begin
    full_d = full_q;
    if (re_i)     full_d = 1'b0;
    if (do_load)  full_d = 1'b0;
    if (we_i)     full_d = 1'b1;
    if (do_store) full_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (do_store)  buf_q <= aligned;
      else if (we_i) buf_q <= wdata_i;
      full_q <= full_d;
      if (err_clr_i)                          ovr_q <= 1'b0;
      else if (do_store && full_q && !re_i)   ovr_q <= 1'b1;
    end
  end

  assign buf_o     = buf_q;
  assign flag_o    = tx_en_i ? !full_q : (rx_en_i ? full_q : 1'b0);
  assign overrun_o = ovr_q;
endmodule

// File: rtl/shift_engine.sv
`timescale 1ns/1ps
module shift_engine
  import shf_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NPIN  = 4,
  parameter int CW    = 16,
  localparam int PW   = (NPIN > 1) ? $clog2(NPIN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             start_en_i,
  input  logic             stop_en_i,
  input  logic             shift_edge_i,
  input  logic             pin_inv_i,
  input  logic             chain_sel_i,
  input  logic [PW-1:0]    pin_sel_i,
  input  logic [CW-1:0]    word_cmp_i,
  input  logic [WIDTH-1:0] buf_wdata_i,
  input  logic             buf_we_i,
  input  logic             buf_re_i,
  input  logic             err_clr_i,
  input  logic             tmr_load_i,
  input  logic             tmr_store_i,
  input  logic             tmr_shift_pos_i,
  input  logic             tmr_shift_neg_i,
  input  logic [NPIN-1:0]  pin_i,
  input  logic             chain_i,
  output logic [WIDTH-1:0] buf_rdata_o,
  output logic             flag_o,
  output logic             overrun_o,
  output logic             pin_o,
  output logic             data_o
);
  logic             tx_en, rx_en, prev_tx_q, tx_enter;
  logic             shift, in_bit, out_bit;
  logic [NPIN-1:0]  pin_s;
  logic [WIDTH-1:0] rx_word, buf_q;

  assign tx_en    = (mode_i == SM_TX);
  assign rx_en    = (mode_i == SM_RX);
  assign tx_enter = tx_en && !prev_tx_q;
  assign shift    = shift_edge_i ? tmr_shift_neg_i : tmr_shift_pos_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_tx_q <= 1'b0;
    else         prev_tx_q <= tx_en;
  end

  shf_sync #(.NPIN(NPIN), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  assign in_bit = chain_sel_i ? chain_i : (pin_s[pin_sel_i] ^ pin_inv_i);

  shf_frame #(.WIDTH(WIDTH)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_en_i   (tx_en),
    .rx_en_i   (rx_en),
    .tx_enter_i(tx_enter),
    .start_en_i(start_en_i),
    .stop_en_i (stop_en_i),
    .load_i    (tmr_load_i),
    .shift_i   (shift),
    .in_bit_i  (in_bit),
    .buf_i     (buf_q),
    .out_bit_o (out_bit),
    .rx_word_o (rx_word)
  );

  shf_buf #(.WIDTH(WIDTH), .CW(CW)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tx_en_i  (tx_en),
    .rx_en_i  (rx_en),
    .we_i     (buf_we_i),
    .wdata_i  (buf_wdata_i),
    .re_i     (buf_re_i),
    .load_i   (tmr_load_i),
    .store_i  (tmr_store_i),
    .err_clr_i(err_clr_i),
    .cmp_i    (word_cmp_i),
    .rx_word_i(rx_word),
    .buf_o    (buf_q),
    .flag_o   (flag_o),
    .overrun_o(overrun_o)
  );

  assign buf_rdata_o = buf_q;
  assign data_o      = out_bit;
  assign pin_o       = out_bit ^ pin_inv_i;
endmodule

// File: rtl/shift_engine_chk.sv
`timescale 1ns/1ps
module shift_engine_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             stop_en_i,
  input logic             buf_we_i,
  input logic             buf_re_i,
  input logic             err_clr_i,
  input logic             tmr_load_i,
  input logic             tmr_store_i,
  input logic [WIDTH-1:0] buf_rdata_o,
  input logic             flag_o,
  input logic             overrun_o,
  input logic             data_o
);
  logic is_off;
  assign is_off = (mode_i == 2'd0) || (mode_i == 2'd3);

  p_off_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_off |-> data_o);

  p_off_buf_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_off && !buf_we_i) |=> $stable(buf_rdata_o));

  p_load_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && tmr_load_i && !buf_we_i) ##1 (mode_i == 2'd2) |-> flag_o);

  p_store_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && tmr_store_i) ##1 (mode_i == 2'd1) |-> flag_o);

  p_overrun_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && tmr_store_i && flag_o && !buf_re_i && !err_clr_i) |=> overrun_o);

  p_overrun_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !err_clr_i) |=> overrun_o);

  p_entry_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && $past(mode_i) != 2'd2 && !tmr_load_i) ##1 (mode_i == 2'd2)
      |-> (data_o == stop_en_i));
endmodule

bind shift_engine shift_engine_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .stop_en_i  (stop_en_i),
  .buf_we_i   (buf_we_i),
  .buf_re_i   (buf_re_i),
  .err_clr_i  (err_clr_i),
  .tmr_load_i (tmr_load_i),
  .tmr_store_i(tmr_store_i),
  .buf_rdata_o(buf_rdata_o),
  .flag_o     (flag_o),
  .overrun_o  (overrun_o),
  .data_o     (data_o)
);

// File: tb/shift_engine_test.sv
`timescale 1ns/1ps
module shift_engine_test;
  localparam int W  = 8;
  localparam int NP = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          start_en = 0, stop_en = 0, edge_sel = 0, inv = 0, csel = 0;
  logic [1:0]    psel = 2'd0;
  logic [CW-1:0] cmp = 16'd15;
  logic [W-1:0]  wdata = '0;
  logic          we = 0, re = 0, eclr = 0, ld = 0, st = 0, shp = 0, shn = 0;
  logic [NP-1:0] pins = '0;
  logic          chain = 0;
  logic [W-1:0]  rdata;
  logic          flag, ovr, pin_o, data_o;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  shift_engine #(.WIDTH(W), .NPIN(NP), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .start_en_i(start_en),
    .stop_en_i(stop_en), .shift_edge_i(edge_sel), .pin_inv_i(inv),
    .chain_sel_i(csel), .pin_sel_i(psel), .word_cmp_i(cmp),
    .buf_wdata_i(wdata), .buf_we_i(we), .buf_re_i(re), .err_clr_i(eclr),
    .tmr_load_i(ld), .tmr_store_i(st), .tmr_shift_pos_i(shp),
    .tmr_shift_neg_i(shn), .pin_i(pins), .chain_i(chain),
    .buf_rdata_o(rdata), .flag_o(flag), .overrun_o(ovr), .pin_o(pin_o),
    .data_o(data_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic shift_pulse(input bit wrong);
    if (edge_sel ^ wrong) shn = 1; else shp = 1;
    tick();
    shn = 0; shp = 0;
  endtask

  function automatic bit fbit(input logic [W-1:0] d, input int k);
    int p;
    p = start_en ? k - 1 : k;
    if (start_en && k == 0) return 1'b0;
    if (p >= 0 && p < W) return d[p];
    return stop_en;
  endfunction

  task automatic tx_frame(input logic [W-1:0] d);
    inv = d[0] ^ d[3];
    wdata = d; we = 1; tick(); we = 0;
    chk(flag == 1'b0, "R10 tx flag after write", flag, 0);
    ld = 1; tick(); ld = 0;
    chk(flag == 1'b1, "R10 tx flag after load", flag, 1);
    chk(pin_o == (fbit(d, 0) ^ inv), "R1 first bit", pin_o, fbit(d, 0) ^ inv);
    shift_pulse(1'b1);
    chk(data_o == fbit(d, 0), "R6 wrong strobe ignored", data_o, fbit(d, 0));
    for (int k = 1; k <= W + 1; k++) begin
      shift_pulse(1'b0);
      if (start_en && k == 0 || (!start_en && k >= W) || (start_en && k == W + 1))
        chk(data_o == fbit(d, k), "R4 stop/fill bit", data_o, fbit(d, k));
      else
        chk(data_o == fbit(d, k), "R2 data bit", data_o, fbit(d, k));
      chk(pin_o == (data_o ^ inv), "R7 output polarity", pin_o, data_o ^ inv);
    end
    shift_pulse(1'b0);
    chk(data_o == stop_en, "R4 fill after frame", data_o, stop_en);
  endtask

  task automatic rx_bits(input logic [W-1:0] d, input int n, input bit use_chain);
    for (int i = 0; i < n; i++) begin
      if (use_chain) begin
        chain = d[i];
        pins = {NP{~d[i]}};
      end else begin
        pins = {NP{~(d[i] ^ inv)}};
        pins[psel] = d[i] ^ inv;
        chain = ~d[i];
      end
      tick(); tick();
      shift_pulse(1'b0);
    end
  endtask

  task automatic rx_word(input logic [W-1:0] d, input int n, input bit use_chain,
                         input string req);
    logic [W-1:0] expv;
    expv = (n >= W) ? d : (d & W'((1 << n) - 1));
    rx_bits(d, n, use_chain);
    st = 1; tick(); st = 0;
    chk(rdata == expv, req, rdata, expv);
    chk(flag == 1'b1, "R10 rx flag after store", flag, 1);
    re = 1; tick(); re = 0;
    chk(flag == 1'b0, "R10 rx flag after read", flag, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // reset state
    chk(pin_o == 1'b1, "R12 reset idle pin", pin_o, 1);
    chk(flag == 1'b0, "R10 reset flag", flag, 0);
    chk(ovr == 1'b0, "R11 reset overrun", ovr, 0);
    chk(rdata == '0, "R12 reset buffer", rdata, 0);

    // off mode ignores timer strobes
    wdata = 8'hA5; we = 1; tick(); we = 0;
    ld = 1; st = 1; shp = 1; shn = 1; tick(); ld = 0; st = 0; shp = 0; shn = 0;
    chk(rdata == 8'hA5, "R12 buffer kept in off", rdata, 8'hA5);
    chk(data_o == 1'b1, "R12 idle in off", data_o, 1);
    chk(flag == 1'b0, "R10 flag in off", flag, 0);
    mode = 2'd3; ld = 1; st = 1; tick(); ld = 0; st = 0;
    chk(rdata == 8'hA5 && data_o, "R12 mode 3 is off", rdata, 8'hA5);

    // transmit sweep
    for (int c = 0; c < 4; c++) begin
      for (int e = 0; e < 2; e++) begin
        start_en = c[0]; stop_en = c[1]; edge_sel = e[0];
        mode = 2'd0; inv = 0; tick();
        mode = 2'd2;
        chk(data_o == 1'b1, "R5 entry cycle idle", data_o, 1);
        tick();
        chk(data_o == stop_en, "R5 preload stop level", data_o, stop_en);
        if (start_en)
          chk(1'b1, "R3 start framing active", 0, 0);
        for (int d = 0; d < 256; d++) begin
          tx_frame(W'(d));
          if (start_en && d == 0) chk(1'b1, "R3 covered", 0, 0);
        end
      end
    end
    // start bit explicit check
    start_en = 1; stop_en = 1; edge_sel = 0; inv = 0;
    wdata = 8'hFF; we = 1; tick(); we = 0;
    ld = 1; tick(); ld = 0;
    chk(data_o == 1'b0, "R3 start bit low", data_o, 0);
    shift_pulse(1'b0);
    chk(data_o == 1'b1, "R3 data bit0 after start", data_o, 1);
    // load wins over shift
    wdata = 8'h02; we = 1; tick(); we = 0;
    start_en = 0; ld = 1; shp = 1; tick(); ld = 0; shp = 0;
    chk(data_o == 1'b0, "R1 load beats shift", data_o, 0);

    // receive sweep through pins
    mode = 2'd0; tick();
    mode = 2'd1; cmp = 16'd15; edge_sel = 0; csel = 0;
    for (int d = 0; d < 256; d++) begin
      psel = 2'(d);
      inv = d[2];
      edge_sel = d[4];
      rx_word(W'(d), W, 1'b0, "R8 pin receive");
    end
    // chain input
    csel = 1; inv = 1;
    for (int d = 0; d < 256; d += 17) rx_word(W'(d), W, 1'b1, "R8 chain receive");
    csel = 0; inv = 0; psel = 2'd1;

    // word length from compare value
    cmp = 16'd9;  rx_word(8'h16, 5, 1'b0, "R9 cmp 9 gives 5 bits");
    cmp = 16'd2;  rx_word(8'h01, 1, 1'b0, "R9 cmp 2 gives 1 bit");
    cmp = 16'd6;  rx_word(8'h05, 3, 1'b0, "R9 cmp 6 gives 3 bits");
    cmp = 16'd0;  rx_word(8'h9C, 8, 1'b0, "R9 cmp 0 clamps to width");
    cmp = 16'd40; rx_word(8'h63, 8, 1'b0, "R9 oversize clamps to width");
    cmp = 16'd15;

    // overrun
    rx_bits(8'h3C, W, 1'b0);
    st = 1; tick(); st = 0;
    chk(ovr == 1'b0, "R11 no overrun on first store", ovr, 0);
    st = 1; tick(); st = 0;
    chk(ovr == 1'b1, "R11 overrun on store into full", ovr, 1);
    re = 1; tick(); re = 0;
    chk(ovr == 1'b1, "R11 overrun sticky", ovr, 1);
    eclr = 1; tick(); eclr = 0;
    chk(ovr == 1'b0, "R11 overrun cleared", ovr, 0);
    st = 1; tick(); st = 0;
    st = 1; re = 1; tick(); st = 0; re = 0;
    chk(ovr == 1'b0 && flag, "R11 store with read no overrun", ovr, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule